// File: doc/BRIEF.md
# Synchronized Chip Configuration Register Update

This block keeps the timing parameters and access-mode settings that a static memory controller applies to each attached chip. Software never writes a chip's live settings directly. It loads one shared pair of staging registers over APB, one for timing and one for mode. It then decides when those staged values become the live settings of a chosen chip.

The copy takes place at one of three moments. The first is an immediate "update only" command. The second is the completion of a mode-register command that the block issues to the memory engine. The third is the completion of an AXI write beat that the host tagged as a set-mode beat. Because the copy lines up with the memory's own mode change, code can keep executing from a chip while that chip changes mode. Accesses before the copy use the old settings and accesses after it use the new ones.

The live settings of every chip are readable over APB but cannot be written there. They also drive flat output buses to the memory engines.

Top module: `cfgsync_mgr`

## Requirements
- R1: After reset, every chip's live timing value equals DEF_CYCLES, and its live mode value equals DEF_OPMODE. Both staging registers read 0, and cmd_valid and cmd_busy are low.
- R2: The staging timing register sits at byte address 0x00 and the staging mode register at 0x04. An APB write to either commits on the clock edge where psel, penable and pwrite are all high, and the new value reads back at once.
- R3: Chip n's live timing reads at 0x40+8n and its live mode at 0x44+8n. APB writes to these addresses change nothing.
- R4: A write to a staging register changes no chip's live settings.
- R5: A write to the command register at 0x08 carries the type in bits [1:0] and the chip number in bits [8+CS_W-1:8]. Type 2 (update only) copies both staging values into the named chip on the same edge as the write. No other chip changes.
- R6: Type 1 (mode write with update) raises cmd_valid for exactly one cycle after the write, with cmd_chip set to the chip and cmd_mode high, and holds cmd_busy high. The live settings stay unchanged until a cmd_done pulse arrives. On that edge the named chip takes the staging values and cmd_busy drops.
- R7: Type 0 (plain command) raises cmd_valid for one cycle with cmd_mode low. Its cmd_done changes no live settings.
- R8: A type 0 or type 1 write made while cmd_busy is high is dropped and raises no cmd_valid. A type 3 write is ignored at all times.
- R9: An AXI arm pulse with axi_arm_flag high arms the chip given by axi_arm_chip. A later axi_done_valid for an armed chip copies the staging values into that chip and disarms it. A done pulse for a chip that is not armed has no effect, and an arm pulse with the flag low arms nothing.
- R10: A deferred copy uses the staging values held at the moment of the copy, including writes made after the command or the arm.
- R11: The act_cycles and act_opmode buses always carry the live settings that the APB reads return, with chip n in slice n.
- R12: A cmd_done pulse while cmd_busy is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, a combinational function of paddr |
| cmd_valid | output | 1 | One-cycle pulse: direct command issued to the memory engine |
| cmd_chip | output | CS_W | Chip addressed by the issued command |
| cmd_mode | output | 1 | Issued command is a mode-register write |
| cmd_busy | output | 1 | A direct command is awaiting completion |
| cmd_done | input | 1 | Memory engine has finished the issued command |
| axi_arm_valid | input | 1 | AXI write beat accepted toward a chip |
| axi_arm_chip | input | CS_W | Chip of that beat |
| axi_arm_flag | input | 1 | Set-mode flag bit taken from the beat's data |
| axi_done_valid | input | 1 | Memory engine has finished an AXI write beat |
| axi_done_chip | input | CS_W | Chip of the finished beat |
| act_cycles | output | NUM_CHIPS*CYC_W | Live timing settings, chip n in slice n |
| act_opmode | output | NUM_CHIPS*OPM_W | Live mode settings, chip n in slice n |

## Verification
Each result has a known clock edge. Staging writes and update-only copies are visible right after the edge on which the APB access phase commits. cmd_valid is high during the one cycle that follows that edge. A deferred copy is visible right after the edge that samples cmd_done or axi_done_valid. The bench drives every input on falling edges and samples on the first falling edge after the edge in question. It then confirms that the pulse is gone one cycle later. Settings that must not move are checked again by reading every chip over APB and on the output buses.

// File: rtl/cfgsync_pkg.sv
package cfgsync_pkg;

    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;
    localparam int DCMD_CHIP_LSB = 8;

    localparam logic [ADDR_W-1:0] ADR_HOLD_CYC = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_HOLD_OPM = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_DCMD     = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_ACT_BASE = 8'h40;

    typedef enum logic [1:0] {
        DCMD_PLAIN  = 2'd0,
        DCMD_MODE   = 2'd1,
        DCMD_UPDATE = 2'd2,
        DCMD_RSVD   = 2'd3
    } dcmd_e;

    // Byte address of a chip's live register: timing first, mode four bytes later.
    function automatic logic [ADDR_W-1:0] act_addr(input int chip, input bit is_opm);
        return ADR_ACT_BASE + ADDR_W'(chip * 8) + (is_opm ? 8'd4 : 8'd0);
    endfunction

endpackage

// File: rtl/cfgsync_chip_regs.sv
module cfgsync_chip_regs #(
    parameter int CYC_W = 24,
    parameter int OPM_W = 16,
    parameter logic [CYC_W-1:0] DEF_CYCLES = '0,
    parameter logic [OPM_W-1:0] DEF_OPMODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] hold_cycles,
    input  logic [OPM_W-1:0] hold_opmode,
    output logic [CYC_W-1:0] act_cycles,
    output logic [OPM_W-1:0] act_opmode
);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [OPM_W-1:0] opm;
    } live_t;

    live_t live_d, live_q;

    always_comb begin
        live_d = live_q;
        if (load) begin
            live_d.cyc = hold_cycles;
            live_d.opm = hold_opmode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q.cyc <= DEF_CYCLES;
            live_q.opm <= DEF_OPMODE;
        end else begin
            live_q <= live_d;
        end
    end

    assign act_cycles = live_q.cyc;
    assign act_opmode = live_q.opm;

endmodule

// File: rtl/cfgsync_apb_regs.sv
module cfgsync_apb_regs
    import cfgsync_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int CYC_W     = 24,
    parameter int OPM_W     = 16,
    parameter int CS_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    output logic [DATA_W-1:0]          prdata,
    input  logic [NUM_CHIPS*CYC_W-1:0] act_cycles,
    input  logic [NUM_CHIPS*OPM_W-1:0] act_opmode,
    output logic [CYC_W-1:0]           hold_cycles,
    output logic [OPM_W-1:0]           hold_opmode,
    output logic                       dcmd_wr,
    output dcmd_e                      dcmd_type,
    output logic [CS_W-1:0]            dcmd_chip
);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [OPM_W-1:0] opm;
    } stage_t;

    stage_t stage_d, stage_q;
    logic   wr_en;
    logic   unused_wdata;

    assign wr_en        = psel & penable & pwrite;
    assign unused_wdata = ^pwdata;

    always_comb begin
        stage_d = stage_q;
        if (wr_en && paddr == ADR_HOLD_CYC) stage_d.cyc = pwdata[CYC_W-1:0];
        if (wr_en && paddr == ADR_HOLD_OPM) stage_d.opm = pwdata[OPM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign hold_cycles = stage_q.cyc;
    assign hold_opmode = stage_q.opm;
    assign dcmd_wr     = wr_en && (paddr == ADR_DCMD);
    assign dcmd_type   = dcmd_e'(pwdata[1:0]);
    assign dcmd_chip   = pwdata[DCMD_CHIP_LSB +: CS_W];

    always_comb begin
        prdata = '0;
        if (paddr == ADR_HOLD_CYC) prdata[CYC_W-1:0] = stage_q.cyc;
        if (paddr == ADR_HOLD_OPM) prdata[OPM_W-1:0] = stage_q.opm;
        for (int c = 0; c < NUM_CHIPS; c++) begin
            if (paddr == act_addr(c, 1'b0)) prdata[CYC_W-1:0] = act_cycles[c*CYC_W +: CYC_W];
            if (paddr == act_addr(c, 1'b1)) prdata[OPM_W-1:0] = act_opmode[c*OPM_W +: OPM_W];
        end
    end

endmodule

// File: rtl/cfgsync_sync_ctl.sv
module cfgsync_sync_ctl
    import cfgsync_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int CS_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dcmd_wr,
    input  dcmd_e                dcmd_type,
    input  logic [CS_W-1:0]      dcmd_chip,
    input  logic                 cmd_done,
    input  logic                 axi_arm_valid,
    input  logic [CS_W-1:0]      axi_arm_chip,
    input  logic                 axi_arm_flag,
    input  logic                 axi_done_valid,
    input  logic [CS_W-1:0]      axi_done_chip,
    output logic [NUM_CHIPS-1:0] load,
    output logic                 cmd_valid,
    output logic [CS_W-1:0]      cmd_chip,
    output logic                 cmd_mode,
    output logic                 cmd_busy
);

    typedef struct packed {
        logic                 pend;
        logic                 pmode;
        logic [CS_W-1:0]      pchip;
        logic                 issue;
        logic [NUM_CHIPS-1:0] armed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 accept;
    logic [NUM_CHIPS-1:0] upd_hit, dir_hit, axi_hit, arm_hit;

    assign accept = dcmd_wr && !ctl_q.pend &&
                    (dcmd_type == DCMD_PLAIN || dcmd_type == DCMD_MODE);

    always_comb begin
        for (int c = 0; c < NUM_CHIPS; c++) begin
            upd_hit[c] = dcmd_wr && dcmd_type == DCMD_UPDATE && dcmd_chip == CS_W'(c);
            dir_hit[c] = cmd_done && ctl_q.pend && ctl_q.pmode && ctl_q.pchip == CS_W'(c);
            axi_hit[c] = axi_done_valid && axi_done_chip == CS_W'(c) && ctl_q.armed[c];
            arm_hit[c] = axi_arm_valid && axi_arm_flag && axi_arm_chip == CS_W'(c);
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.issue = 1'b0;
        if (cmd_done && ctl_q.pend) ctl_d.pend = 1'b0;
        if (accept) begin
            ctl_d.pend  = 1'b1;
            ctl_d.pmode = (dcmd_type == DCMD_MODE);
            ctl_d.pchip = dcmd_chip;
            ctl_d.issue = 1'b1;
        end
        ctl_d.armed = (ctl_q.armed & ~axi_hit) | arm_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign load      = upd_hit | dir_hit | axi_hit;
    assign cmd_valid = ctl_q.issue;
    assign cmd_chip  = ctl_q.pchip;
    assign cmd_mode  = ctl_q.pmode;
    assign cmd_busy  = ctl_q.pend;

endmodule

// File: rtl/cfgsync_mgr.sv
module cfgsync_mgr
    import cfgsync_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int CYC_W     = 24,
    parameter int OPM_W     = 16,
    parameter logic [CYC_W-1:0] DEF_CYCLES = 24'h020406,
    parameter logic [OPM_W-1:0] DEF_OPMODE = 16'h0081,
    localparam int CS_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [7:0]                 paddr,
    input  logic [31:0]                pwdata,
    output logic [31:0]                prdata,
    output logic                       cmd_valid,
    output logic [CS_W-1:0]            cmd_chip,
    output logic                       cmd_mode,
    output logic                       cmd_busy,
    input  logic                       cmd_done,
    input  logic                       axi_arm_valid,
    input  logic [CS_W-1:0]            axi_arm_chip,
    input  logic                       axi_arm_flag,
    input  logic                       axi_done_valid,
    input  logic [CS_W-1:0]            axi_done_chip,
    output logic [NUM_CHIPS*CYC_W-1:0] act_cycles,
    output logic [NUM_CHIPS*OPM_W-1:0] act_opmode
);

    logic [CYC_W-1:0]     hold_cyc;
    logic [OPM_W-1:0]     hold_opm;
    logic                 dcmd_wr;
    dcmd_e                dcmd_type;
    logic [CS_W-1:0]      dcmd_chip;
    logic [NUM_CHIPS-1:0] load_vec;

    cfgsync_apb_regs #(
        .NUM_CHIPS(NUM_CHIPS), .CYC_W(CYC_W), .OPM_W(OPM_W), .CS_W(CS_W)
    ) u_apb (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .act_cycles(act_cycles), .act_opmode(act_opmode),
        .hold_cycles(hold_cyc), .hold_opmode(hold_opm),
        .dcmd_wr(dcmd_wr), .dcmd_type(dcmd_type), .dcmd_chip(dcmd_chip)
    );

    cfgsync_sync_ctl #(
        .NUM_CHIPS(NUM_CHIPS), .CS_W(CS_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .dcmd_wr(dcmd_wr), .dcmd_type(dcmd_type), .dcmd_chip(dcmd_chip),
        .cmd_done(cmd_done),
        .axi_arm_valid(axi_arm_valid), .axi_arm_chip(axi_arm_chip),
        .axi_arm_flag(axi_arm_flag),
        .axi_done_valid(axi_done_valid), .axi_done_chip(axi_done_chip),
        .load(load_vec),
        .cmd_valid(cmd_valid), .cmd_chip(cmd_chip), .cmd_mode(cmd_mode),
        .cmd_busy(cmd_busy)
    );

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        cfgsync_chip_regs #(
            .CYC_W(CYC_W), .OPM_W(OPM_W),
            .DEF_CYCLES(DEF_CYCLES), .DEF_OPMODE(DEF_OPMODE)
        ) u_regs (
            .clk(clk), .rst_n(rst_n),
            .load(load_vec[c]),
            .hold_cycles(hold_cyc), .hold_opmode(hold_opm),
            .act_cycles(act_cycles[c*CYC_W +: CYC_W]),
            .act_opmode(act_opmode[c*OPM_W +: OPM_W])
        );
    end

endmodule

// File: rtl/cfgsync_mgr_chk.sv
module cfgsync_mgr_chk #(
    parameter int NUM_CHIPS = 4,
    parameter int CYC_W     = 24,
    parameter int OPM_W     = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CHIPS-1:0]       load,
    input logic [CYC_W-1:0]           hold_cycles,
    input logic [OPM_W-1:0]           hold_opmode,
    input logic [NUM_CHIPS*CYC_W-1:0] act_cycles,
    input logic [NUM_CHIPS*OPM_W-1:0] act_opmode,
    input logic                       cmd_valid,
    input logic                       cmd_busy,
    input logic                       cmd_done,
    input logic                       dcmd_wr,
    input logic [1:0]                 dcmd_type,
    input logic                       axi_done_valid
);

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chk
        AST_LOAD_TAKES_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
            load[c] |=> (act_cycles[c*CYC_W +: CYC_W] == $past(hold_cycles) &&
                         act_opmode[c*OPM_W +: OPM_W] == $past(hold_opmode))); // R10

        AST_IDLE_CHIP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !load[c] |=> ($stable(act_cycles[c*CYC_W +: CYC_W]) &&
                          $stable(act_opmode[c*OPM_W +: OPM_W]))); // R4
    end

    AST_LOAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|load) |-> ((dcmd_wr && dcmd_type == 2'd2) || cmd_done || axi_done_valid)); // R9

    AST_ONE_CHIP_PER_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!axi_done_valid) |-> $onehot0(load)); // R5

    AST_ISSUE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R6

    AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_busy); // R8

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && cmd_done) |=> !cmd_busy); // R6

endmodule

bind cfgsync_mgr cfgsync_mgr_chk #(
    .NUM_CHIPS(NUM_CHIPS), .CYC_W(CYC_W), .OPM_W(OPM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .load(load_vec),
    .hold_cycles(hold_cyc), .hold_opmode(hold_opm),
    .act_cycles(act_cycles), .act_opmode(act_opmode),
    .cmd_valid(cmd_valid), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .dcmd_wr(dcmd_wr), .dcmd_type(dcmd_type),
    .axi_done_valid(axi_done_valid)
);

// File: tb/cfgsync_mgr_bench.sv
`timescale 1ns/1ps
module cfgsync_mgr_bench;
    import cfgsync_pkg::*;

    localparam int NCH = 4;
    localparam int CW  = 24;
    localparam int OW  = 16;
    localparam int SW  = 2;
    localparam logic [CW-1:0] DEFC = 24'h020406;
    localparam logic [OW-1:0] DEFO = 16'h0081;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic cmd_valid, cmd_mode, cmd_busy;
    logic [SW-1:0] cmd_chip;
    logic cmd_done = 0;
    logic axi_arm_valid = 0, axi_arm_flag = 0, axi_done_valid = 0;
    logic [SW-1:0] axi_arm_chip = '0, axi_done_chip = '0;
    logic [NCH*CW-1:0] act_cycles;
    logic [NCH*OW-1:0] act_opmode;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [CW-1:0] exp_cyc [NCH];
    logic [OW-1:0] exp_opm [NCH];

    always #4 clk = ~clk;

    cfgsync_mgr #(.NUM_CHIPS(NCH), .CYC_W(CW), .OPM_W(OW),
                  .DEF_CYCLES(DEFC), .DEF_OPMODE(DEFO)) u_cfgsync_mgr (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cmd_valid(cmd_valid), .cmd_chip(cmd_chip), .cmd_mode(cmd_mode),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .axi_arm_valid(axi_arm_valid), .axi_arm_chip(axi_arm_chip),
        .axi_arm_flag(axi_arm_flag), .axi_done_valid(axi_done_valid),
        .axi_done_chip(axi_done_chip),
        .act_cycles(act_cycles), .act_opmode(act_opmode)
    );

    function automatic logic [CW-1:0] mk_cyc(input int seed);
        return CW'(32'h00010203 * (seed + 1) + 32'h00000F11 * seed);
    endfunction
    function automatic logic [OW-1:0] mk_opm(input int seed);
        return OW'((32'h0135 * (seed + 3)) ^ 32'h5A00);
    endfunction
    function automatic logic [31:0] dcmd_word(input int chip, input int typ);
        return (32'(chip) << DCMD_CHIP_LSB) | 32'(typ);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic stage(input int seed);
        apb_write(ADR_HOLD_CYC, 32'(mk_cyc(seed)));
        apb_write(ADR_HOLD_OPM, 32'(mk_opm(seed)));
    endtask

    task automatic check_all(input string req);
        logic [31:0] rd;
        for (int c = 0; c < NCH; c++) begin
            apb_read(act_addr(c, 1'b0), rd);
            chk(req, rd, 32'(exp_cyc[c]));
            apb_read(act_addr(c, 1'b1), rd);
            chk(req, rd, 32'(exp_opm[c]));
            chk({req, " R11 bus"}, 32'(act_cycles[c*CW +: CW]), 32'(exp_cyc[c]));
            chk({req, " R11 bus"}, 32'(act_opmode[c*OW +: OW]), 32'(exp_opm[c]));
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); cmd_done = 1;
        @(negedge clk); cmd_done = 0;
    endtask

    task automatic axi_arm(input int c, input logic flag);
        @(negedge clk); axi_arm_valid = 1; axi_arm_chip = SW'(c); axi_arm_flag = flag;
        @(negedge clk); axi_arm_valid = 0; axi_arm_flag = 0;
    endtask

    task automatic axi_done(input int c);
        @(negedge clk); axi_done_valid = 1; axi_done_chip = SW'(c);
        @(negedge clk); axi_done_valid = 0;
    endtask

    // Issue a direct command; returns on the falling edge right after its commit edge.
    task automatic issue(input int c, input int typ);
        apb_write(ADR_DCMD, dcmd_word(c, typ));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        for (int c = 0; c < NCH; c++) begin exp_cyc[c] = DEFC; exp_opm[c] = DEFO; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check_all("R1 defaults");
        apb_read(ADR_HOLD_CYC, rd); chk("R1 stage cyc", rd, 0);
        apb_read(ADR_HOLD_OPM, rd); chk("R1 stage opm", rd, 0);
        chk("R1 cmd_valid", 32'(cmd_valid), 0);
        chk("R1 cmd_busy", 32'(cmd_busy), 0);

        // R2 + R4: staging writes read back and touch no chip
        stage(7);
        apb_read(ADR_HOLD_CYC, rd); chk("R2 stage cyc", rd, 32'(mk_cyc(7)));
        apb_read(ADR_HOLD_OPM, rd); chk("R2 stage opm", rd, 32'(mk_opm(7)));
        check_all("R4 stage only");

        // R3: live registers are read-only
        for (int c = 0; c < NCH; c++) begin
            apb_write(act_addr(c, 1'b0), 32'h00ABCDEF);
            apb_write(act_addr(c, 1'b1), 32'h0000BEEF);
        end
        check_all("R3 ro");

        // R5: update-only sweep over every chip
        for (int c = 0; c < NCH; c++) begin
            stage(10 + c);
            issue(c, 2);
            chk("R5 no issue", 32'(cmd_valid), 0);
            exp_cyc[c] = mk_cyc(10 + c); exp_opm[c] = mk_opm(10 + c);
            check_all("R5 update");
        end

        // R6 + R10: mode write with deferred copy, staging rewritten while pending
        for (int c = 0; c < NCH; c++) begin
            stage(20 + c);
            issue(c, 1);
            chk("R6 valid", 32'(cmd_valid), 1);
            chk("R6 chip", 32'(cmd_chip), 32'(c));
            chk("R6 mode", 32'(cmd_mode), 1);
            chk("R6 busy", 32'(cmd_busy), 1);
            @(negedge clk);
            chk("R6 one shot", 32'(cmd_valid), 0);
            stage(30 + c);
            check_all("R6 held");
            pulse_done();
            chk("R6 busy clear", 32'(cmd_busy), 0);
            exp_cyc[c] = mk_cyc(30 + c); exp_opm[c] = mk_opm(30 + c);
            check_all("R10 latest");
        end

        // R7: plain command copies nothing
        stage(40);
        issue(1, 0);
        chk("R7 valid", 32'(cmd_valid), 1);
        chk("R7 mode", 32'(cmd_mode), 0);
        pulse_done();
        check_all("R7 plain");

        // R8: commands while busy are dropped; reserved type ignored
        stage(50);
        issue(2, 1);
        chk("R8 first valid", 32'(cmd_valid), 1);
        issue(3, 1);
        chk("R8 dropped mode", 32'(cmd_valid), 0);
        issue(3, 0);
        chk("R8 dropped plain", 32'(cmd_valid), 0);
        pulse_done();
        exp_cyc[2] = mk_cyc(50); exp_opm[2] = mk_opm(50);
        check_all("R8 busy");
        stage(55);
        issue(0, 3);
        chk("R8 rsvd valid", 32'(cmd_valid), 0);
        chk("R8 rsvd busy", 32'(cmd_busy), 0);
        check_all("R8 rsvd");

        // R12: stray completion
        pulse_done();
        check_all("R12 stray done");

        // R9 + R10: AXI-tagged update per chip
        for (int c = 0; c < NCH; c++) begin
            stage(60 + c);
            axi_arm(c, 1'b1);
            axi_done((c + 1) % NCH);
            check_all("R9 other chip");
            stage(70 + c);
            axi_done(c);
            exp_cyc[c] = mk_cyc(70 + c); exp_opm[c] = mk_opm(70 + c);
            check_all("R9 fire");
            stage(80 + c);
            axi_done(c);
            check_all("R9 disarmed");
        end
        axi_arm(2, 1'b0);
        axi_done(2);
        check_all("R9 no flag");

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule